// File: doc/BRIEF.md
# Receive Data Holding Register with Error Flags

This block is the one-entry holding register that sits between a serial receive front-end and the register bus of a UART. The front-end hands over each completed character with a one-cycle strobe, along with a noise indication and a framing-error indication. The block keeps the character, raises a data-ready flag, and keeps three sticky error flags: overrun, noise and framing.

The bus side sees two plain read strobes, one for the status register and one for the data register. A data read frees the holding register. The error flags clear only through a two-step sequence. First the status register is read, which arms the clear for the flags set at that moment. A later data read then clears them.

The block produces one interrupt line. Its sources depend on whether DMA receive mode is on. In DMA receive mode the block also raises a request line while data is ready, and treats the DMA acknowledge as a data read.

Top module: `rxhold_top`

## Requirements
- R1: A character accepted into an empty holding register appears on `rd_data`, with `st_ready` at 1, from the cycle after its `frm_valid` strobe.
- R2: A data read (`data_rd`, or `dma_ack` while `dma_mode` is 1) clears `st_ready` on the next cycle. If a new character arrives in the same cycle as the read, that character is accepted, `st_ready` stays 1, and no overrun is flagged.
- R3: If a character arrives while `st_ready` is 1 and there is no read in that cycle, `st_overrun` is set. That character is discarded, and `rd_data` keeps the older byte.
- R4: A character accepted with `frm_noise` at 1 is still stored. `st_noise` rises in the same cycle as `st_ready`.
- R5: A character accepted with `frm_ferr` at 1 is still stored. `st_framing` rises in the same cycle as `st_ready`.
- R6: A data read that follows no status read leaves overrun, noise and framing unchanged. A status read followed by a later data read clears the flags that were set at the time of the status read.
- R7: An error flag set after the arming status read survives the data read that ends the sequence. A second status read before the data read keeps the clear armed.
- R8: With `rx_ie` at 1, `irq` is 1 whenever `st_ready` or `st_overrun` is 1.
- R9: Noise and framing errors raise `irq` only when both `err_ie` and `dma_mode` are 1. Overrun also raises `irq` under that condition.
- R10: `dma_req` equals `st_ready` while `dma_mode` is 1 and is 0 otherwise. `dma_ack` has no effect while `dma_mode` is 0.
- R11: After reset, `st_ready`, all error flags, `irq`, `dma_req` and `rd_data` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| frm_valid | input | 1 | Completed-character strobe from the front-end |
| frm_data | input | DATA_W | Received character |
| frm_noise | input | 1 | Noise seen on this character |
| frm_ferr | input | 1 | Stop bit missing on this character |
| stat_rd | input | 1 | Status register read strobe |
| data_rd | input | 1 | Data register read strobe |
| rx_ie | input | 1 | Receive interrupt enable |
| err_ie | input | 1 | Error interrupt enable |
| dma_mode | input | 1 | DMA receive mode |
| dma_ack | input | 1 | DMA acknowledge, acts as a data read in DMA mode |
| rd_data | output | DATA_W | Holding register contents |
| st_ready | output | 1 | Data-ready flag |
| st_overrun | output | 1 | Overrun flag |
| st_noise | output | 1 | Noise flag |
| st_framing | output | 1 | Framing-error flag |
| irq | output | 1 | Interrupt request |
| dma_req | output | 1 | DMA request |

## Verification
Two pairs of events can land in the same cycle. A character can arrive in the same cycle as the data read that frees the register. A new error can be set in the same cycle as, or after, the status read that arms the clear. The bench provokes both: it aligns `frm_valid` with `data_rd` or `dma_ack`, and it injects noisy characters between a status read and the data read that follows it. A behavioural model decides whether each character is kept or discarded, and which flags the sequence clears. That model is compared with every output on every clock.

// File: rtl/rxhold_pkg.sv
`timescale 1ns/1ps
package rxhold_pkg;
  localparam int ERR_N     = 3;
  localparam int ERR_OVR   = 0;
  localparam int ERR_NOISE = 1;
  localparam int ERR_FRM   = 2;

  typedef logic [ERR_N-1:0] err_vec_t;

  // flags after one cycle: clear the armed set, then OR in fresh events
  function automatic err_vec_t err_next(err_vec_t cur, err_vec_t set_v, err_vec_t clr_v);
    return (cur & ~clr_v) | set_v;
  endfunction

  function automatic logic irq_calc(logic rdy, err_vec_t e, logic rx_ie,
                                    logic err_ie, logic dma_on);
    logic rx_src;
    logic dma_src;
    rx_src  = rx_ie & (rdy | e[ERR_OVR]);
    dma_src = err_ie & dma_on & (|e);
    return rx_src | dma_src;
  endfunction

  // a character is taken when the register is free or freed this cycle
  function automatic logic can_accept(logic rdy, logic rd_now);
    return !rdy || rd_now;
  endfunction
endpackage

// File: rtl/rxhold_store.sv
`timescale 1ns/1ps
module rxhold_store #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frm_valid,
  input  logic [DATA_W-1:0] frm_data,
  input  logic              rd_evt,
  output logic              ready_q,
  output logic [DATA_W-1:0] buf_q,
  output logic              accept,
  output logic              ovr_evt
);
  import rxhold_pkg::*;

  assign accept  = frm_valid && can_accept(ready_q, rd_evt);
  assign ovr_evt = frm_valid && !accept;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ready_q <= 1'b0;
      buf_q   <= '0;
    end else begin
      if (accept) begin
        ready_q <= 1'b1;
        buf_q   <= frm_data;
      end else if (rd_evt) begin
        ready_q <= 1'b0;
      end
    end
  end

  a_r1_accept_loads: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (ready_q && buf_q == $past(frm_data)));
  a_r2_read_frees: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_evt && !frm_valid) |=> !ready_q);
  a_r3_keep_on_overrun: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_evt |=> ($stable(buf_q) && ready_q));
endmodule

// File: rtl/rxhold_errseq.sv
`timescale 1ns/1ps
module rxhold_errseq
  import rxhold_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  err_vec_t err_set,
  input  logic     stat_rd,
  input  logic     rd_evt,
  output err_vec_t flags_q,
  output logic     arm_q
);
  err_vec_t mask_q;
  err_vec_t clr_v;
  logic     fire;

  assign fire  = arm_q && rd_evt;
  assign clr_v = fire ? mask_q : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
      mask_q  <= '0;
      arm_q   <= 1'b0;
    end else begin
      flags_q <= err_next(flags_q, err_set, clr_v);
      if (stat_rd) begin
        arm_q  <= 1'b1;
        mask_q <= rd_evt ? flags_q : (mask_q | flags_q);
      end else if (rd_evt) begin
        arm_q  <= 1'b0;
        mask_q <= '0;
      end
    end
  end

  a_r6_hold_unarmed: assert property (@(posedge clk) disable iff (!rst_n)
    !fire |=> ((flags_q | ~$past(flags_q)) == '1));
  a_r7_new_err_survives: assert property (@(posedge clk) disable iff (!rst_n)
    (err_set != '0) |=> ((flags_q & $past(err_set)) == $past(err_set)));
  a_r7_status_keeps_arm: assert property (@(posedge clk) disable iff (!rst_n)
    stat_rd |=> arm_q);
endmodule

// File: rtl/rxhold_irq.sv
`timescale 1ns/1ps
module rxhold_irq
  import rxhold_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     rdy,
  input  err_vec_t flags,
  input  logic     rx_ie,
  input  logic     err_ie,
  input  logic     dma_on,
  output logic     irq,
  output logic     dma_req
);
  assign irq     = irq_calc(rdy, flags, rx_ie, err_ie, dma_on);
  assign dma_req = dma_on & rdy;

  a_r9_no_err_irq_outside_dma: assert property (@(posedge clk) disable iff (!rst_n)
    (!dma_on && !rx_ie) |-> !irq);
  a_r8_rx_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_ie && rdy) |-> irq);
  a_r10_req_needs_data: assert property (@(posedge clk) disable iff (!rst_n)
    dma_req |-> rdy);
endmodule

// File: rtl/rxhold_top.sv
`timescale 1ns/1ps
module rxhold_top
  import rxhold_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frm_valid,
  input  logic [DATA_W-1:0] frm_data,
  input  logic              frm_noise,
  input  logic              frm_ferr,
  input  logic              stat_rd,
  input  logic              data_rd,
  input  logic              rx_ie,
  input  logic              err_ie,
  input  logic              dma_mode,
  input  logic              dma_ack,
  output logic [DATA_W-1:0] rd_data,
  output logic              st_ready,
  output logic              st_overrun,
  output logic              st_noise,
  output logic              st_framing,
  output logic              irq,
  output logic              dma_req
);
  logic     rd_evt;
  logic     accept;
  logic     ovr_evt;
  logic     arm_q;
  err_vec_t err_set;
  err_vec_t flags;

  assign rd_evt = data_rd | (dma_ack & dma_mode);

  always_comb begin
    err_set            = '0;
    err_set[ERR_OVR]   = ovr_evt;
    err_set[ERR_NOISE] = accept & frm_noise;
    err_set[ERR_FRM]   = accept & frm_ferr;
  end

  rxhold_store #(.DATA_W(DATA_W)) u_store (
    .clk(clk), .rst_n(rst_n), .frm_valid(frm_valid), .frm_data(frm_data),
    .rd_evt(rd_evt), .ready_q(st_ready), .buf_q(rd_data),
    .accept(accept), .ovr_evt(ovr_evt)
  );

  rxhold_errseq u_err (
    .clk(clk), .rst_n(rst_n), .err_set(err_set), .stat_rd(stat_rd),
    .rd_evt(rd_evt), .flags_q(flags), .arm_q(arm_q)
  );

  rxhold_irq u_irq (
    .clk(clk), .rst_n(rst_n), .rdy(st_ready), .flags(flags),
    .rx_ie(rx_ie), .err_ie(err_ie), .dma_on(dma_mode),
    .irq(irq), .dma_req(dma_req)
  );

  assign st_overrun = flags[ERR_OVR];
  assign st_noise   = flags[ERR_NOISE];
  assign st_framing = flags[ERR_FRM];

  a_r4_noise_with_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && frm_noise) |=> (st_noise && st_ready));
  a_r5_framing_with_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && frm_ferr) |=> (st_framing && st_ready));
  a_r10_ack_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (!dma_mode && dma_ack && !data_rd && !frm_valid && st_ready) |=> st_ready);
endmodule

// File: tb/sim_rxhold_top.sv
`timescale 1ns/1ps
module sim_rxhold_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic frm_valid = 0, frm_noise = 0, frm_ferr = 0;
  logic [7:0] frm_data = 0;
  logic stat_rd = 0, data_rd = 0, dma_ack = 0;
  logic rx_ie = 0, err_ie = 0, dma_mode = 0;
  logic [7:0] rd_data;
  logic st_ready, st_overrun, st_noise, st_framing, irq, dma_req;

  int checks = 0;
  int failures = 0;

  // reference state
  bit m_rdy, m_ovr, m_nse, m_frm, m_arm;
  bit m_k_ovr, m_k_nse, m_k_frm;
  int m_buf;

  always #2 clk = ~clk;

  rxhold_top u0 (
    .clk(clk), .rst_n(rst_n), .frm_valid(frm_valid), .frm_data(frm_data),
    .frm_noise(frm_noise), .frm_ferr(frm_ferr), .stat_rd(stat_rd),
    .data_rd(data_rd), .rx_ie(rx_ie), .err_ie(err_ie), .dma_mode(dma_mode),
    .dma_ack(dma_ack), .rd_data(rd_data), .st_ready(st_ready),
    .st_overrun(st_overrun), .st_noise(st_noise), .st_framing(st_framing),
    .irq(irq), .dma_req(dma_req)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic bit exp_irq();
    bit v = 0;
    if (rx_ie && (m_rdy || m_ovr)) v = 1;
    if (err_ie && dma_mode && (m_ovr || m_nse || m_frm)) v = 1;
    return v;
  endfunction

  task automatic compare_all();
    chk("R1 rd_data", rd_data, m_buf);
    chk("R2 st_ready", st_ready, m_rdy);
    chk("R3 st_overrun", st_overrun, m_ovr);
    chk("R4 st_noise", st_noise, m_nse);
    chk("R5 st_framing", st_framing, m_frm);
    chk("R8/R9 irq", irq, exp_irq());
    chk("R10 dma_req", dma_req, dma_mode && m_rdy);
  endtask

  task automatic tick(bit fv, int fd, bit fn, bit ff, bit sr, bit dr, bit da);
    bit rd_now, take, lost, fire;
    bit n_rdy, n_ovr, n_nse, n_frm, n_arm, n_ko, n_kn, n_kf;
    int n_buf;
    @(negedge clk);
    frm_valid = fv; frm_data = fd[7:0]; frm_noise = fn; frm_ferr = ff;
    stat_rd = sr; data_rd = dr; dma_ack = da;
    rd_now = dr || (da && dma_mode);
    take = fv && (!m_rdy || rd_now);
    lost = fv && !take;
    fire = m_arm && rd_now;
    n_rdy = m_rdy; n_buf = m_buf;
    if (take) begin n_rdy = 1; n_buf = fd & 8'hFF; end
    else if (rd_now) n_rdy = 0;
    n_ovr = (m_ovr && !(fire && m_k_ovr)) || lost;
    n_nse = (m_nse && !(fire && m_k_nse)) || (take && fn);
    n_frm = (m_frm && !(fire && m_k_frm)) || (take && ff);
    n_arm = m_arm; n_ko = m_k_ovr; n_kn = m_k_nse; n_kf = m_k_frm;
    if (sr) begin
      n_arm = 1;
      if (rd_now) begin n_ko = m_ovr; n_kn = m_nse; n_kf = m_frm; end
      else begin n_ko = m_k_ovr | m_ovr; n_kn = m_k_nse | m_nse; n_kf = m_k_frm | m_frm; end
    end else if (rd_now) begin
      n_arm = 0; n_ko = 0; n_kn = 0; n_kf = 0;
    end
    @(posedge clk);
    #1;
    m_rdy = n_rdy; m_buf = n_buf; m_ovr = n_ovr; m_nse = n_nse; m_frm = n_frm;
    m_arm = n_arm; m_k_ovr = n_ko; m_k_nse = n_kn; m_k_frm = n_kf;
    compare_all();
  endtask

  task automatic idle(); tick(0, 0, 0, 0, 0, 0, 0); endtask

  initial begin
    #800000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R11 reset state
    chk("R11 ready", st_ready, 0); chk("R11 flags", {st_overrun, st_noise, st_framing}, 0);
    chk("R11 irq", irq, 0); chk("R11 dma_req", dma_req, 0); chk("R11 data", rd_data, 0);
    @(negedge clk); rst_n = 1;
    rx_ie = 1;
    tick(1, 'hA5, 0, 0, 0, 0, 0);
    chk("R1 stored", rd_data, 'hA5); chk("R8 irq on ready", irq, 1);
    tick(1, 'h3C, 0, 0, 0, 0, 0);
    chk("R3 overrun", st_overrun, 1); chk("R3 old byte kept", rd_data, 'hA5);
    tick(0, 0, 0, 0, 0, 1, 0);
    chk("R2 read clears ready", st_ready, 0); chk("R6 unarmed read keeps overrun", st_overrun, 1);
    chk("R8 irq from overrun", irq, 1);
    tick(0, 0, 0, 0, 1, 0, 0);
    tick(1, 'h11, 1, 0, 0, 0, 0);
    chk("R4 noise with ready", st_noise & st_ready, 1);
    tick(0, 0, 0, 0, 0, 1, 0);
    chk("R6 overrun cleared", st_overrun, 0); chk("R7 late noise survives", st_noise, 1);
    tick(0, 0, 0, 0, 1, 0, 0);
    tick(0, 0, 0, 0, 1, 0, 0);
    tick(0, 0, 0, 0, 0, 1, 0);
    chk("R7 second status read keeps arm", st_noise, 0);
    tick(1, 'h5A, 0, 1, 0, 0, 0);
    chk("R5 framing with ready", st_framing & st_ready, 1);
    // R9: error irq routing
    rx_ie = 0; err_ie = 1;
    tick(0, 0, 0, 0, 0, 1, 0);
    chk("R9 no error irq outside DMA", irq, 0);
    dma_mode = 1;
    tick(1, 'h77, 0, 0, 0, 0, 0);
    chk("R9 error irq in DMA", irq, 1); chk("R10 dma_req", dma_req, 1);
    tick(1, 'h78, 0, 0, 0, 0, 1);
    chk("R2 frame with ack accepted", rd_data, 'h78); chk("R2 no overrun", st_overrun, 0);
    tick(0, 0, 0, 0, 0, 0, 1);
    chk("R10 ack reads", st_ready, 0);
    dma_mode = 0;
    tick(1, 'h99, 0, 0, 0, 0, 0);
    tick(0, 0, 0, 0, 0, 0, 1);
    chk("R10 ack ignored outside DMA", st_ready, 1);
    tick(1, 'h42, 0, 0, 0, 1, 0);
    chk("R2 read and frame same cycle", rd_data, 'h42); chk("R2 ready held", st_ready, 1);
    // mixed traffic
    for (int i = 0; i < 400; i++) begin
      rx_ie = $urandom_range(0, 1); err_ie = $urandom_range(0, 1);
      dma_mode = $urandom_range(0, 1);
      tick($urandom_range(0, 2) == 0, $urandom_range(0, 255),
           $urandom_range(0, 3) == 0, $urandom_range(0, 3) == 0,
           $urandom_range(0, 3) == 0, $urandom_range(0, 3) == 0,
           $urandom_range(0, 3) == 0);
    end
    idle();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule